// File: doc/BRIEF.md
# Pointer Load Value Predictor (address-minus-delta)

This block guesses the value that a pointer-producing load will return when that load misses in the second-level cache while the core is executing speculatively ahead of a long miss. With a guessed pointer in hand, the loads that depend on it can form their own addresses and send their misses to memory early, alongside the first miss, instead of being marked invalid.

The guess rests on one observation. For many pointer loads, the difference between the load's effective address and the value it loads stays constant from one execution to the next. The block keeps this difference, called the delta, in a small set-associative table tagged by the load's program counter. Each entry also holds a saturating confidence count.

Loads retiring in normal execution train the table through an update port. Loads whose delta lies outside a configurable magnitude window are taken to be data loads and are not recorded. Speculative cache-miss loads query the table through a lookup port. One cycle later the block answers with a valid flag and the value address minus stored delta. A wrong guess only costs speculative work, so nothing is ever rolled back.

Top module: `avd_predictor`

## Requirements
- R1: While reset is high and in the first cycle after it, `pred_valid` is 0. After reset every table entry is empty.
- R2: On update, the delta is `upd_addr - upd_data`, taken modulo 2^32 and read as a signed 32-bit number. A confident prediction drives `pred_value = lkp_addr - stored delta`, modulo 2^32.
- R3: An update whose signed delta is greater than `MAX_AVD` or less than `-MAX_AVD` leaves the table untouched. Deltas of exactly `+MAX_AVD` and `-MAX_AVD` are recorded. `MAX_AVD` is 65536 by default.
- R4: An update for a PC that is not in the table allocates an entry with confidence 0. Each later update with the same delta adds 1 to the confidence. A prediction needs a confidence of 2 or more, so the third identical update is the first one that enables it.
- R5: An update for a stored PC whose delta differs from the stored one replaces the delta and clears the confidence to 0. This stops predictions for that PC.
- R6: The 2-bit confidence saturates at 3. After any number of matching updates, a single mismatching update still stops predictions.
- R7: A lookup presented in cycle N is answered at the outputs after the clock edge that ends cycle N. A cycle with `lkp_valid` low yields `pred_valid` = 0 in the following cycle.
- R8: An update and a lookup in the same cycle are both served. The lookup sees the table as it was before that update.
- R9: The set is chosen by the low log2(SETS) bits of the PC. Each set holds WAYS entries, 4 sets of 4 ways by default. Allocation evicts the entry least recently written by an update. Lookups do not change the replacement order.
- R10: A lookup that misses the table, or that hits an entry with confidence below 2, gives `pred_valid` = 0 and `pred_value` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | A load retires in normal mode this cycle |
| upd_pc | input | PC_W | PC of the retiring load |
| upd_addr | input | 32 | Effective address of the retiring load |
| upd_data | input | 32 | Value loaded by the retiring load |
| lkp_valid | input | 1 | A speculative load missed in L2 this cycle |
| lkp_pc | input | PC_W | PC of the missing load |
| lkp_addr | input | 32 | Effective address of the missing load |
| pred_valid | output | 1 | The registered prediction is usable |
| pred_value | output | 32 | Predicted loaded value, 0 when not valid |

## Verification
Any corruption of a stored delta appears at the ports on the first confident lookup to that PC, one cycle after the request, as a `pred_value` that differs from address minus trained delta.

A wrong confidence count shows up within three updates. The prediction flag then turns on one update too early or too late, or stays on after a mismatch.

A broken replacement order stays hidden until a set overflows. From then on, a lookup to the entry that should have survived returns no prediction, or a lookup to the evicted entry still returns one.

The bench runs a behavioural model next to the block, with a recency-ordered queue per set, and compares both outputs on every clock.

// File: rtl/avd_pkg.sv
package avd_pkg;
  localparam int AVD_W = 32;

  // signed window test on a 32-bit delta
  function automatic logic avd_in_window(input logic [AVD_W-1:0] d, input longint maxv);
    longint s;
    s = longint'($signed(d));
    return (s >= -maxv) && (s <= maxv);
  endfunction
endpackage

// File: rtl/avd_delta_filter.sv
module avd_delta_filter
  import avd_pkg::*;
#(
  parameter longint MAX_AVD = 65536
) (
  input  logic [AVD_W-1:0] addr,
  input  logic [AVD_W-1:0] data,
  output logic [AVD_W-1:0] delta,
  output logic             keep
);
  always_comb begin
    delta = addr - data;
    keep  = avd_in_window(delta, MAX_AVD);
  end
endmodule

// File: rtl/avd_set.sv
module avd_set
  import avd_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int WAYS    = 4,
  parameter int CONF_W  = 2,
  parameter int CONF_TH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [AVD_W-1:0] upd_delta,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_ok,
  output logic [AVD_W-1:0] lk_delta
);
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [AGE_W-1:0]  OLDEST   = AGE_W'(WAYS - 1);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [CONF_W-1:0] CONF_REQ = CONF_W'(CONF_TH);

  logic [WAYS-1:0]   vld;
  logic [PC_W-1:0]   tag  [WAYS];
  logic [AVD_W-1:0]  dlt  [WAYS];
  logic [CONF_W-1:0] conf [WAYS];
  logic [AGE_W-1:0]  age  [WAYS];

  logic [WAYS-1:0]  u_hit, l_hit, oldest, tgt;
  logic [AGE_W-1:0] tgt_age;

  always_comb begin
    tgt_age  = '0;
    lk_ok    = 1'b0;
    lk_delta = '0;
    for (int w = 0; w < WAYS; w++) begin
      u_hit[w]  = vld[w] && (tag[w] == upd_pc);
      l_hit[w]  = vld[w] && (tag[w] == lk_pc);
      oldest[w] = (age[w] == OLDEST);
    end
    tgt = (u_hit != '0) ? u_hit : oldest;
    for (int w = 0; w < WAYS; w++) begin
      if (tgt[w]) tgt_age = tgt_age | age[w];
      if (l_hit[w]) begin
        lk_ok    = lk_ok | (conf[w] >= CONF_REQ);
        lk_delta = lk_delta | dlt[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) begin
        vld[w]  <= 1'b0;
        tag[w]  <= '0;
        dlt[w]  <= '0;
        conf[w] <= '0;
        age[w]  <= AGE_W'(w);
      end
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (tgt[w]) begin
          vld[w] <= 1'b1;
          tag[w] <= upd_pc;
          age[w] <= '0;
          if (u_hit[w] && (dlt[w] == upd_delta)) begin
            if (conf[w] != CONF_MAX) conf[w] <= conf[w] + 1'b1;
          end else begin
            dlt[w]  <= upd_delta;
            conf[w] <= '0;
          end
        end else if (age[w] < tgt_age) begin
          age[w] <= age[w] + 1'b1;
        end
      end
    end
  end

  // R9: a PC lives in at most one way of its set
  a_r9_single_match: assert property (@(posedge clk) disable iff (rst) $onehot0(l_hit));
  // R9: replacement ages stay a permutation, so exactly one victim exists
  a_r9_one_victim: assert property (@(posedge clk) disable iff (rst) $onehot(oldest));
endmodule

// File: rtl/avd_predictor.sv
module avd_predictor
  import avd_pkg::*;
#(
  parameter int     PC_W    = 32,
  parameter int     SETS    = 4,
  parameter int     WAYS    = 4,
  parameter int     CONF_W  = 2,
  parameter int     CONF_TH = 2,
  parameter longint MAX_AVD = 65536
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [AVD_W-1:0] upd_addr,
  input  logic [AVD_W-1:0] upd_data,
  input  logic             lkp_valid,
  input  logic [PC_W-1:0]  lkp_pc,
  input  logic [AVD_W-1:0] lkp_addr,
  output logic             pred_valid,
  output logic [AVD_W-1:0] pred_value
);
  localparam int SET_W = $clog2(SETS);

  logic [AVD_W-1:0] upd_delta;
  logic             upd_keep;
  logic [SET_W-1:0] u_idx, l_idx;
  logic [SETS-1:0]  s_ok;
  logic [AVD_W-1:0] s_dlt [SETS];
  logic             hit_ok;

  avd_delta_filter #(.MAX_AVD(MAX_AVD)) u_filter (
    .addr(upd_addr), .data(upd_data), .delta(upd_delta), .keep(upd_keep)
  );

  assign u_idx  = upd_pc[SET_W-1:0];
  assign l_idx  = lkp_pc[SET_W-1:0];
  assign hit_ok = lkp_valid && s_ok[l_idx];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    avd_set #(.PC_W(PC_W), .WAYS(WAYS), .CONF_W(CONF_W), .CONF_TH(CONF_TH)) u_set (
      .clk(clk), .rst(rst),
      .upd_en(upd_valid && upd_keep && (u_idx == SET_W'(s))),
      .upd_pc(upd_pc), .upd_delta(upd_delta),
      .lk_pc(lkp_pc), .lk_ok(s_ok[s]), .lk_delta(s_dlt[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_value <= '0;
    end else begin
      pred_valid <= hit_ok;
      pred_value <= hit_ok ? (lkp_addr - s_dlt[l_idx]) : '0;
    end
  end

  // R1: first cycle out of reset carries no prediction
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !pred_valid);
  // R7: no request, no answer
  a_r7_no_req: assert property (@(posedge clk) disable iff (rst) !$past(lkp_valid) |-> !pred_valid);
  // R3: every prediction implies a delta inside the window
  a_r3_window: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> avd_in_window($past(lkp_addr) - pred_value, MAX_AVD));
  // R10: an invalid answer carries a zero value
  a_r10_zero: assert property (@(posedge clk) disable iff (rst) !pred_valid |-> pred_value == '0);
endmodule

// File: tb/avd_predictor_test.sv
module avd_predictor_test;
  localparam int     SETS = 4;
  localparam int     WAYS = 4;
  localparam longint MAXV = 65536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0, lkp_valid = 1'b0;
  logic [31:0] upd_pc = '0, upd_addr = '0, upd_data = '0, lkp_pc = '0, lkp_addr = '0;
  logic        pred_valid;
  logic [31:0] pred_value;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  avd_predictor uut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_addr(upd_addr),
    .upd_data(upd_data), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc), .lkp_addr(lkp_addr),
    .pred_valid(pred_valid), .pred_value(pred_value)
  );

  typedef struct { logic [31:0] pc; logic [31:0] d; int conf; } ent_t;
  ent_t mq [SETS][$];   // front = most recently updated

  function automatic void model_lookup(input logic [31:0] pc, input logic [31:0] addr,
                                       output bit v, output logic [31:0] val);
    int s = int'(pc % SETS);
    v = 0; val = '0;
    foreach (mq[s][i]) if (mq[s][i].pc == pc && mq[s][i].conf >= 2) begin
      v = 1; val = addr - mq[s][i].d;
    end
  endfunction

  function automatic void model_update(input logic [31:0] pc, input logic [31:0] addr,
                                       input logic [31:0] data);
    int s = int'(pc % SETS);
    logic [31:0] d = addr - data;
    longint sd = longint'($signed(d));
    ent_t e;
    int idx = -1;
    if (sd > MAXV || sd < -MAXV) return;
    foreach (mq[s][i]) if (mq[s][i].pc == pc) idx = i;
    if (idx >= 0) begin
      e = mq[s][idx];
      mq[s].delete(idx);
      if (e.d == d) begin if (e.conf < 3) e.conf++; end
      else begin e.d = d; e.conf = 0; end
    end else begin
      if (mq[s].size() == WAYS) void'(mq[s].pop_back());
      e.pc = pc; e.d = d; e.conf = 0;
    end
    mq[s].push_front(e);
  endfunction

  task automatic check(input string tag, input bit ev, input logic [31:0] eval);
    checks++;
    if (pred_valid !== ev || pred_value !== eval) begin
      errors++;
      $display("FAIL %s: got valid=%0b value=%08h, expected valid=%0b value=%08h",
               tag, pred_valid, pred_value, ev, eval);
    end
  endtask

  // one cycle: inputs set after a negedge, answer checked at the next negedge
  task automatic cyc(input bit uv, input logic [31:0] upc, input logic [31:0] ua,
                     input logic [31:0] ud, input bit lv, input logic [31:0] lpc,
                     input logic [31:0] la, input string tag);
    bit ev; logic [31:0] eval;
    upd_valid = uv; upd_pc = upc; upd_addr = ua; upd_data = ud;
    lkp_valid = lv; lkp_pc = lpc; lkp_addr = la;
    if (lv) model_lookup(lpc, la, ev, eval); else begin ev = 0; eval = '0; end
    if (uv) model_update(upc, ua, ud);
    @(posedge clk);
    @(negedge clk);
    upd_valid = 0; lkp_valid = 0;
    check(tag, ev, eval);
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] a, input logic [31:0] d,
                     input string tag);
    cyc(1, pc, a, d, 0, '0, '0, tag);
  endtask
  task automatic lk(input logic [31:0] pc, input logic [31:0] a, input string tag);
    cyc(0, '0, '0, '0, 1, pc, a, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", 0, '0);
    rst = 0;
    check("R1 after reset", 0, '0);
    lk(32'h100, 32'h2000, "R10 empty table");

    // R4: three identical updates before a prediction, delta +16
    upd(32'h100, 32'h1000, 32'h0FF0, "R4 alloc");
    lk(32'h100, 32'h2000, "R4 conf0");
    upd(32'h100, 32'h1100, 32'h10F0, "R4 second");
    lk(32'h100, 32'h2000, "R4 conf1");
    // R8: third update together with a lookup sees the old confidence
    cyc(1, 32'h100, 32'h1200, 32'h11F0, 1, 32'h100, 32'h2000, "R8 same cycle");
    lk(32'h100, 32'h2000, "R2 predicts addr-16");
    cyc(0, '0, '0, '0, 0, '0, '0, "R7 idle after hit");

    // R2: negative delta, set 1
    for (int i = 0; i < 3; i++) upd(32'h201, 32'h5000, 32'h5040, "R2 neg train");
    lk(32'h201, 32'h9000, "R2 negative delta");

    // R3: out-of-range updates ignored, boundaries kept
    upd(32'h100, 32'h0002_0001, 32'h0000_0000, "R3 too big");
    lk(32'h100, 32'h3000, "R3 entry untouched");
    upd(32'h100, 32'h0000_0000, 32'h0001_0001, "R3 too negative");
    lk(32'h100, 32'h3000, "R3 entry untouched neg");
    for (int i = 0; i < 3; i++) upd(32'h305, 32'h0001_0000, 32'h0, "R3 +max train");
    lk(32'h305, 32'h0004_0000, "R3 +max kept");
    for (int i = 0; i < 3; i++) upd(32'h309, 32'h0, 32'h0001_0000, "R3 -max train");
    lk(32'h309, 32'h10, "R3 -max kept");

    // R5: mismatch resets confidence and retrains
    upd(32'h100, 32'h1000, 32'h0FE0, "R5 mismatch");
    lk(32'h100, 32'h4000, "R5 no pred after mismatch");
    upd(32'h100, 32'h2000, 32'h1FE0, "R5 retrain");
    upd(32'h100, 32'h3000, 32'h2FE0, "R5 retrain");
    lk(32'h100, 32'h4000, "R5 new delta predicted");

    // R6: saturation then a single mismatch
    for (int i = 0; i < 6; i++) upd(32'h100, 32'h7000, 32'h6FE0, "R6 saturate");
    lk(32'h100, 32'h8000, "R6 saturated pred");
    upd(32'h100, 32'h7000, 32'h7000, "R6 one mismatch");
    lk(32'h100, 32'h8000, "R6 drop after mismatch");

    // R9: fill set 2, touch first, allocate a fifth
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 3; i++) upd(32'h2 + 32'(4 * p), 32'h1000, 32'h0F00, "R9 fill");
    for (int p = 0; p < 4; p++) lk(32'h2 + 32'(4 * p), 32'h500, "R9 all present");
    lk(32'h6, 32'h500, "R9 lookup keeps order");
    upd(32'h2, 32'h1000, 32'h0F00, "R9 touch first");
    upd(32'h12, 32'h1000, 32'h0F00, "R9 fifth alloc");
    lk(32'h6, 32'h500, "R9 LRU evicted");
    lk(32'h2, 32'h500, "R9 touched kept");
    lk(32'hA, 32'h500, "R9 others kept");
    lk(32'h100, 32'h500, "R9 other set unaffected");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule